// File: doc/BRIEF.md
# Generalized Bit Reverse Network

This block permutes the bits of a data word through a chain of swap stages, one stage for each power of two below the word width. Each stage exchanges neighbouring groups of equal size, and one bit of a control operand turns it on or off. Because the stages can be enabled in any combination, the same network gives full bit reversal, bit reversal inside each byte, byte-order reversal, halfword swaps and every other pattern that the stages combine into.

A control decoder turns the control operand into a set of stage strobes. A datapath holds the stage chain and, when the `REG_OUT` parameter is set, a result register. The width is set by `XLEN`, which may be 32 or 64. Instruction decode, register files and other arithmetic sit outside this block.

Top module: `bitperm_grev`

## Requirements
- R1: The network has log2(XLEN) stages. Stage k has a swap distance of 2^k and runs only when bit k of `ctrlAmt` is 1. XLEN is 32 (5 stages) or 64 (6 stages).
- R2: An enabled stage with distance d and mask m computes ((x AND m) << d) OR ((x AND NOT m) >> d). Bit i of m is 1 exactly when bit k of the index i is 0. This gives 0x55, 0x33 and 0x0F in every byte, then the low byte of each halfword, the low halfword of each word, and the low 32 bits.
- R3: Stages run in ascending order of distance, and any combination of enabled stages composes in that order.
- R4: Bits of `ctrlAmt` at positions log2(XLEN) and above have no effect on the result.
- R5: A control value of 0 passes the source word through unchanged.
- R6: A control value of XLEN-8 reverses the byte order of the word.
- R7: A control value of XLEN-1 reverses the full word bit by bit.
- R8: A control value of 7 reverses the bit order inside each byte and leaves every byte in its place.
- R9: With `REG_OUT`=1, the result for the operands present at a rising clock edge appears on `resWord` just after that edge. An active-low reset clears `resWord` to 0. With `REG_OUT`=0 the output is combinational.
- R10: The number of 1 bits in the result equals the number in the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rstN | input | 1 | Asynchronous active-low reset |
| srcWord | input | XLEN | Word to permute |
| ctrlAmt | input | XLEN | Control operand; bit k enables stage k |
| resWord | output | XLEN | Permuted word |

## Verification
Several stages enabled in the same evaluation must compose in ascending order, and this is where a wrong stage order or a wrong mask would show. The bench covers it by sweeping every control value, and so every combination of stages, over many random words. Each result is compared with a bench loop model that builds its masks from the index rule. Byte reversal, full reversal and reversal inside bytes are also checked against slicing that is written independently of the loop model. Control values with random upper bits set must give the same result as their low bits alone.

// File: rtl/grev_pkg.sv
package grev_pkg;

  // Largest supported stage count (XLEN = 64).
  localparam int MAX_STAGES = 6;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic [MAX_STAGES-1:0] stageEn;
  } grevStrobe_t;

  // Swap mask for stage k: bit i set when index bit k is clear.
  function automatic logic [63:0] stageMask(input int k);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      m[i] = (((i >> k) & 1) == 0);
    end
    return m;
  endfunction

endpackage

// File: rtl/grev_ctrl.sv
module grev_ctrl
  import grev_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int STAGES = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] ctrlAmt,
  output grevStrobe_t     strobe
);

  // Upper control bits are deliberately dropped (R4).
  logic unusedHi;
  assign unusedHi = ^ctrlAmt[XLEN-1:STAGES];

  always_comb begin
    strobe = '0;
    for (int k = 0; k < STAGES; k++) begin
      strobe.stageEn[k] = ctrlAmt[k];
    end
  end

endmodule

// File: rtl/grev_datapath.sv
module grev_datapath
  import grev_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int STAGES  = $clog2(XLEN),
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] srcWord,
  input  grevStrobe_t     strobe,
  output logic [XLEN-1:0] resWord
);

  localparam logic [STAGES-1:0] BSWAP_CTL = STAGES'(XLEN - 8);
  localparam logic [STAGES-1:0] FULL_CTL  = '1;

  logic [XLEN-1:0] stageVal [STAGES+1];
  logic [XLEN-1:0] netOut;
  logic [STAGES-1:0] activeEn;

  assign activeEn    = strobe.stageEn[STAGES-1:0];
  assign stageVal[0] = srcWord;

  // Swap stages, ascending distance (R1, R2, R3).
  for (genvar k = 0; k < STAGES; k++) begin : gStage
    localparam logic [63:0] MASK_FULL = stageMask(k);
    localparam logic [XLEN-1:0] MASK  = MASK_FULL[XLEN-1:0];
    localparam int DIST = 1 << k;
    logic [XLEN-1:0] swapped;
    assign swapped = ((stageVal[k] & MASK) << DIST) | ((stageVal[k] & ~MASK) >> DIST);
    assign stageVal[k+1] = activeEn[k] ? swapped : stageVal[k];
  end

  assign netOut = stageVal[STAGES];

  if (STAGES < MAX_STAGES) begin : gSpare
    logic unusedSpare;
    assign unusedSpare = ^strobe.stageEn[MAX_STAGES-1:STAGES];
  end

  if (REG_OUT) begin : gReg
    logic [XLEN-1:0] resReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resReg <= '0;
      else       resReg <= netOut;
    end
    assign resWord = resReg;

    // R9
    reg_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> resWord == $past(netOut));
  end else begin : gComb
    logic unusedClk;
    assign unusedClk = clk ^ rstN;
    assign resWord = netOut;
  end

  // R10
  ones_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(netOut) == $countones(srcWord));

  // R5
  identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeEn == '0) |-> netOut == srcWord);

  // R6
  byte_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeEn == BSWAP_CTL) |-> netOut == {<<8{srcWord}});

  // R7
  full_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeEn == FULL_CTL) |-> netOut == {<<{srcWord}});

endmodule

// File: rtl/bitperm_grev.sv
module bitperm_grev
  import grev_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] srcWord,
  input  logic [XLEN-1:0] ctrlAmt,
  output logic [XLEN-1:0] resWord
);

  localparam int STAGES = $clog2(XLEN);

  initial begin
    // R1
    xlen_ok_chk: assert (XLEN == 32 || XLEN == 64);
  end

  grevStrobe_t strobe;

  grev_ctrl #(.XLEN(XLEN), .STAGES(STAGES)) uCtrl (
    .ctrlAmt (ctrlAmt),
    .strobe  (strobe)
  );

  grev_datapath #(.XLEN(XLEN), .STAGES(STAGES), .REG_OUT(REG_OUT)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .srcWord (srcWord),
    .strobe  (strobe),
    .resWord (resWord)
  );

endmodule

// File: tb/bitperm_grev_test.sv
`timescale 1ns/1ps
module bitperm_grev_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] srcWord = '0;
  logic [W-1:0] ctrlAmt = '0;
  logic [W-1:0] resWord;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitperm_grev #(.XLEN(W), .REG_OUT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .srcWord(srcWord), .ctrlAmt(ctrlAmt), .resWord(resWord)
  );

  // Loop model: ascending distances, mask from index rule.
  function automatic logic [W-1:0] refModel(logic [W-1:0] x, logic [W-1:0] c);
    logic [W-1:0] m;
    for (int d = 1; d < W; d = d * 2) begin
      if ((c & d) != 0) begin
        for (int i = 0; i < W; i++) m[i] = (((i / d) % 2) == 0);
        x = ((x & m) << d) | ((x & ~m) >> d);
      end
    end
    return x;
  endfunction

  function automatic logic [W-1:0] byteRev(logic [W-1:0] x);
    logic [W-1:0] r;
    for (int b = 0; b < W/8; b++) r[8*b +: 8] = x[8*(W/8-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [W-1:0] bitRev(logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] inByteRev(logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[(i/8)*8 + 7 - (i%8)];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge; register captures at posedge; sample next negedge (R9).
  task automatic apply(logic [W-1:0] s, logic [W-1:0] c);
    @(negedge clk);
    srcWord = s;
    ctrlAmt = c;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s;
    logic [W-1:0] c;
    void'($urandom(1234));
    srcWord = 32'hDEADBEEF;
    ctrlAmt = 32'h1F;
    repeat (3) @(negedge clk);
    check("R9 reset clears result", resWord, '0);
    rstN = 1'b1;

    // R9 latency: result follows operands one edge later
    apply(32'h12345678, 32'h0);
    check("R5 identity", resWord, 32'h12345678);
    @(negedge clk);
    srcWord = 32'h0000_00FF;
    ctrlAmt = 32'd24;
    #1;
    check("R9 no change before edge", resWord, 32'h12345678);
    @(negedge clk);
    check("R9 byte swap after edge", resWord, 32'hFF00_0000);

    // Directed corner cases
    apply(32'h11223344, W - 8);
    check("R6 byte reversal", resWord, 32'h44332211);
    apply(32'h0000_0001, W - 1);
    check("R7 full reversal", resWord, 32'h8000_0000);
    apply(32'h0102_0480, 7);
    check("R8 reverse in bytes", resWord, 32'h8040_2001);
    apply(32'hAAAA_AAAA, 1);
    check("R2 stage 0 mask", resWord, 32'h5555_5555);
    apply(32'hFFFF_0000, 16);
    check("R2 stage 4 mask", resWord, 32'h0000_FFFF);

    // Random words over every control value
    for (int cv = 0; cv < W; cv++) begin
      for (int n = 0; n < 12; n++) begin
        s = $urandom();
        apply(s, cv);
        check("R3 composed stages", resWord, refModel(s, cv));
        check("R10 ones kept", W'($countones(resWord)), W'($countones(s)));
      end
    end

    // Upper control bits ignored
    for (int n = 0; n < 64; n++) begin
      s = $urandom();
      c = $urandom();
      apply(s, c);
      check("R4 upper bits ignored", resWord, refModel(s, c & 32'h1F));
    end

    // Named patterns vs independent slicing, random words
    for (int n = 0; n < 24; n++) begin
      s = $urandom();
      apply(s, W - 8);
      check("R6 random byte reversal", resWord, byteRev(s));
      apply(s, W - 1);
      check("R7 random bit reversal", resWord, bitRev(s));
      apply(s, 7);
      check("R8 random in-byte reversal", resWord, inByteRev(s));
      apply(s, 0);
      check("R5 random identity", resWord, s);
      apply(s, 32'hFFFF_FFE0);
      check("R1 R4 only high bits set", resWord, s);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule